// File: doc/BRIEF.md
# Cascadable Framed Serial Codec Port

This block is the device-side serial port of one unit in a daisy chain of codec units that share a single host serial port. It generates the serial clock for the link. It receives 16-bit words on a data input, each framed by an input frame sync, and transmits 16-bit words on a data output, each framed by an output frame sync. Words may arrive with an idle cycle between them, or back to back with the next frame sync overlapping the last bit of the current word.

A 3-bit cascade-length field gives the number of units in the chain minus one. Within one sample interval the unit counts the words it receives. The words that belong to units further down the chain are shifted out again, unchanged, on the serial output with a fresh frame sync. The final word of the interval belongs to this unit. It is loaded into the DAC holding register and announced with a one-cycle strobe. A sample-interval pulse from the rate logic restarts the count.

Top module: `cascade_serial_port`

## Requirements
- R1: The serial clock `sclk` is produced inside the block. It is low after reset, toggles every `SCLK_HALF` clock cycles, and so has a period of 2*`SCLK_HALF` clock cycles.
- R2: `sdi_fs` and `sdi` are sampled at each falling `sclk` edge. A high `sdi_fs` sample marks the next 16 samples of `sdi` as one word, most significant bit first.
- R3: When `sdi_fs` is high at the sample that carries bit 0 of a word, the next word starts at the following sample with no idle cycle, and both words are received intact.
- R4: With `casc_len` = N, the (N+1)-th word received since the last DAC update or interval start is written to `dac_word`. `dac_strobe` is high for exactly one clock cycle at that time. With N = 0, every word updates the DAC register.
- R5: Each of the first N words of an interval is retransmitted on `sdo`, most significant bit first, in arrival order, and is not written to `dac_word`. `sdo_fs` is high for one `sclk` period immediately before the first bit of each retransmitted word.
- R6: `sdo` and `sdo_fs` change only at rising `sclk` edges. When no word is being sent, both are low.
- R7: A one-cycle `interval_start` pulse clears the word count, so the word count restarts from the first word of the chain.
- R8: During reset, `sclk`, `sdo`, `sdo_fs`, `dac_strobe` and `dac_word` are all zero.
- R9: `dac_word` changes only in the cycle in which `dac_strobe` is high.
- R10: The largest chain, `casc_len` = 7 (eight units), forwards seven back-to-back words and keeps the eighth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| casc_len | input | 3 | Number of units in the chain minus one |
| interval_start | input | 1 | One-cycle pulse at the start of each sample interval |
| sdi | input | 1 | Serial data input |
| sdi_fs | input | 1 | Input frame sync, active high |
| sclk | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial data output |
| sdo_fs | output | 1 | Output frame sync, active high |
| dac_word | output | 16 | DAC holding register |
| dac_strobe | output | 1 | One-cycle pulse when `dac_word` is loaded |

## Verification
The hardest case to reach from the ports is an eight-unit chain driven back to back. Here the receive side finishes a word while the transmit side is still shifting out the previous forwarded word, and the single pending slot must hand over on the rising edge that carries the last bit. The bench drives seven forwarded words with overlapping frame syncs at `casc_len` = 7. It deframes `sdo` independently of the design and compares every forwarded word and the kept word. A separate directed case pulses `interval_start` partway through an interval and checks that the count restarts.

// File: rtl/csp_pkg.sv
// Package: shared constants and types for the cascade serial port.
// Assumes one fixed word length for both directions and a 3-bit chain field.
package csp_pkg;
    localparam int WORD_W   = 16;
    localparam int CASC_W   = 3;
    localparam int BITCNT_W = $clog2(WORD_W + 1);
    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [CASC_W-1:0]   casc_t;
    typedef logic [BITCNT_W-1:0] bitcnt_t;
endpackage

// File: rtl/csp_sclk_gen.sv
// Serial clock generator: divides clk down to the serial clock.
// Assumes SCLK_HALF >= 1. The rise/fall event outputs are high in the clk
// cycle whose closing edge moves sclk, so that logic clocked by clk can act
// on that same edge.
module csp_sclk_gen #(
    parameter int SCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int DIV_W = $clog2(SCLK_HALF + 1);

    logic [DIV_W-1:0] div_q;
    logic             sclk_q;
    logic             wrap;

    assign wrap     = (div_q == DIV_W'(SCLK_HALF - 1));
    assign rise_evt = wrap & ~sclk_q;
    assign fall_evt = wrap &  sclk_q;
    assign sclk     = sclk_q;

    // Count half periods and toggle the serial clock at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/csp_rx_deframer.sv
// Receive deframer: samples sdi/sdi_fs on falling serial clock edges and
// assembles MSB-first words. A frame sync sample arms the next sample as bit
// 15; a sync that arrives together with bit 0 chains the next word directly.
// Assumes the inputs are stable around the falling edge of sclk.
module csp_rx_deframer
    import csp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fall_evt,
    input  logic  sdi,
    input  logic  sdi_fs,
    output logic  word_valid,
    output word_t word_data
);
    logic    go_q;
    logic    active_q;
    bitcnt_t cnt_q;
    word_t   sh_q;

    // Shift in one bit per falling edge and emit a word after the 16th bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q       <= 1'b0;
            active_q   <= 1'b0;
            cnt_q      <= '0;
            sh_q       <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= 1'b0;
            if (fall_evt) begin
                go_q <= sdi_fs;
                if (go_q) begin
                    sh_q     <= {sh_q[WORD_W-2:0], sdi};
                    cnt_q    <= bitcnt_t'(1);
                    active_q <= 1'b1;
                end else if (active_q) begin
                    sh_q <= {sh_q[WORD_W-2:0], sdi};
                    if (cnt_q == bitcnt_t'(WORD_W - 1)) begin
                        active_q   <= 1'b0;
                        cnt_q      <= '0;
                        word_valid <= 1'b1;
                        word_data  <= {sh_q[WORD_W-2:0], sdi};
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/csp_frame_router.sv
// Frame router: counts received words within a sample interval. Words before
// the last one of the chain are passed to the transmitter; the last one loads
// the DAC holding register with a one-cycle strobe. An interval pulse restarts
// the count, and a word that completes in that same cycle counts as the first.
// Assumes casc_len is changed only between intervals; a count at or above it
// still ends the interval.
module csp_frame_router
    import csp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  casc_t casc_len,
    input  logic  interval_start,
    input  logic  word_valid,
    input  word_t word_data,
    output logic  fwd_valid,
    output word_t fwd_word,
    output word_t dac_word,
    output logic  dac_strobe
);
    casc_t idx_q;
    casc_t idx_eff;

    // Position of the incoming word in the interval, after any restart.
    always_comb idx_eff = interval_start ? '0 : idx_q;

    // Route each word either downstream or into the DAC register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            fwd_valid  <= 1'b0;
            fwd_word   <= '0;
            dac_word   <= '0;
            dac_strobe <= 1'b0;
        end else begin
            fwd_valid  <= 1'b0;
            dac_strobe <= 1'b0;
            if (word_valid) begin
                if (idx_eff >= casc_len) begin
                    dac_word   <= word_data;
                    dac_strobe <= 1'b1;
                    idx_q      <= '0;
                end else begin
                    fwd_valid <= 1'b1;
                    fwd_word  <= word_data;
                    idx_q     <= idx_eff + 1'b1;
                end
            end else begin
                idx_q <= idx_eff;
            end
        end
    end
endmodule

// File: rtl/csp_tx_framer.sv
// Transmit framer: holds one pending forwarded word and sends it MSB first
// on rising serial clock edges, with a one-period frame sync before bit 15.
// When the pending word is ready during the last bit of the current word,
// its sync overlaps that bit, so words go out back to back.
// Assumes forwarded words arrive no faster than one per 16 serial clocks.
module csp_tx_framer
    import csp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rise_evt,
    input  logic  fwd_valid,
    input  word_t fwd_word,
    output logic  sdo,
    output logic  sdo_fs
);
    logic    pend_valid_q;
    word_t   pend_q;
    word_t   sh_q;
    bitcnt_t left_q;
    logic    take;

    // Start a new word when idle or when the current one ends on this edge.
    assign take = rise_evt & pend_valid_q & (left_q <= bitcnt_t'(1));

    // Single-entry holding slot between the router and the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid_q <= 1'b0;
            pend_q       <= '0;
        end else begin
            if (take) begin
                pend_valid_q <= 1'b0;
            end
            if (fwd_valid) begin
                pend_valid_q <= 1'b1;
                pend_q       <= fwd_word;
            end
        end
    end

    // Drive sync and data bits on each rising serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            sdo    <= 1'b0;
            sdo_fs <= 1'b0;
        end else if (rise_evt) begin
            sdo_fs <= take;
            if (left_q != '0) begin
                sdo <= sh_q[WORD_W-1];
            end else begin
                sdo <= 1'b0;
            end
            if (take) begin
                sh_q   <= pend_q;
                left_q <= bitcnt_t'(WORD_W);
            end else if (left_q != '0) begin
                sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
                left_q <= left_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cascade_serial_port.sv
// Top level: serial port of one unit in a codec chain. It ties together the
// serial clock generator, receive deframer, frame router and transmit framer.
// Assumes interval_start comes from the sample-rate logic as a one-cycle pulse.
module cascade_serial_port
    import csp_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CASC_W-1:0] casc_len,
    input  logic              interval_start,
    input  logic              sdi,
    input  logic              sdi_fs,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_fs,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_strobe
);
    logic  rise_evt;
    logic  fall_evt;
    logic  rx_valid;
    word_t rx_word;
    logic  fwd_valid;
    word_t fwd_word;

    csp_sclk_gen #(.SCLK_HALF(SCLK_HALF)) clkgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    csp_rx_deframer rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_evt   (fall_evt),
        .sdi        (sdi),
        .sdi_fs     (sdi_fs),
        .word_valid (rx_valid),
        .word_data  (rx_word)
    );

    csp_frame_router router_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .casc_len       (casc_len),
        .interval_start (interval_start),
        .word_valid     (rx_valid),
        .word_data      (rx_word),
        .fwd_valid      (fwd_valid),
        .fwd_word       (fwd_word),
        .dac_word       (dac_word),
        .dac_strobe     (dac_strobe)
    );

    csp_tx_framer tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_evt  (rise_evt),
        .fwd_valid (fwd_valid),
        .fwd_word  (fwd_word),
        .sdo       (sdo),
        .sdo_fs    (sdo_fs)
    );
endmodule

// File: rtl/csp_port_chk.sv
// Checker: timing properties of the serial port observed at its ports.
// Attached to every instance of the top module by the bind below.
module csp_port_chk
    import csp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              sdo,
    input logic              sdo_fs,
    input logic [WORD_W-1:0] dac_word,
    input logic              dac_strobe
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_strobe |=> !dac_strobe);                                   // R4
    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_word) |-> dac_strobe);                            // R9
    AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $rose(sclk));                                // R6
    AST_SDOFS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_fs) |-> $rose(sclk));                             // R5
    AST_SCLK_RESET: assert property (@(posedge clk)
        !rst_n |=> !sclk);                                             // R1
endmodule

bind cascade_serial_port csp_port_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .sdo        (sdo),
    .sdo_fs     (sdo_fs),
    .dac_word   (dac_word),
    .dac_strobe (dac_strobe)
);

// File: tb/cascade_serial_port_tb_top.sv
module cascade_serial_port_tb_top;
    localparam int HALF = 2;

    // Each vector: {casc_len[2:0], back_to_back, base_word[15:0]}
    localparam logic [19:0] VECS [0:5] = '{
        {3'd0, 1'b0, 16'hA5C3},
        {3'd1, 1'b1, 16'h8001},
        {3'd2, 1'b0, 16'h7FFE},
        {3'd3, 1'b1, 16'h1234},
        {3'd7, 1'b1, 16'hF00F},
        {3'd5, 1'b0, 16'h0F0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  casc_len = 3'd0;
    logic        interval_start = 1'b0;
    logic        sdi = 1'b0;
    logic        sdi_fs = 1'b0;
    logic        sclk;
    logic        sdo;
    logic        sdo_fs;
    logic [15:0] dac_word;
    logic        dac_strobe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // Independent deframer of the serial output and DAC monitor state.
    logic [15:0] fwd_q [0:15];
    int          fwd_n = 0;
    int          dac_n = 0;
    logic [15:0] dac_last = '0;
    bit          m_go = 0;
    bit          m_active = 0;
    int          m_cnt = 0;
    logic [15:0] m_sh = '0;

    cascade_serial_port #(.SCLK_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .casc_len(casc_len),
        .interval_start(interval_start), .sdi(sdi), .sdi_fs(sdi_fs),
        .sclk(sclk), .sdo(sdo), .sdo_fs(sdo_fs),
        .dac_word(dac_word), .dac_strobe(dac_strobe)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge sclk) begin
        if (rst_n) begin
            if (m_go) begin
                m_sh = {15'b0, sdo};
                m_cnt = 1;
                m_active = 1;
            end else if (m_active) begin
                m_sh = {m_sh[14:0], sdo};
                m_cnt++;
                if (m_cnt == 16) begin
                    if (fwd_n < 16) fwd_q[fwd_n] = m_sh;
                    fwd_n++;
                    m_active = 0;
                end
            end
            m_go = sdo_fs;
        end
    end

    always @(negedge clk) begin
        if (dac_strobe) begin
            dac_n++;
            dac_last = dac_word;
        end
    end

    function automatic logic [15:0] mkword(logic [15:0] base, int i);
        return base + 16'(i) * 16'h0111;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_interval();
        @(negedge clk) interval_start = 1'b1;
        @(negedge clk) interval_start = 1'b0;
    endtask

    // Drive n words starting at base, framed with or without overlap.
    task automatic send_words(int n, bit b2b, logic [15:0] base);
        @(posedge sclk); #1; sdi = 1'b0; sdi_fs = 1'b1;
        for (int i = 0; i < n; i++) begin
            for (int b = 15; b >= 0; b--) begin
                @(posedge sclk); #1;
                sdi = mkword(base, i)[b];
                sdi_fs = (b == 0) && b2b && (i < n - 1);
            end
            if (!b2b && i < n - 1) begin
                @(posedge sclk); #1; sdi = 1'b0; sdi_fs = 1'b1;
            end
        end
        @(posedge sclk); #1; sdi = 1'b0; sdi_fs = 1'b0;
    endtask

    task automatic drain();
        repeat (40) @(posedge sclk);
        #3;
    endtask

    task automatic clear_mon();
        fwd_n = 0;
        dac_n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (4) @(posedge clk);
        #2;
        chk(sclk == 1'b0, "R8 sclk", 32'(sclk), 0);
        chk(sdo == 1'b0 && sdo_fs == 1'b0, "R8 sdo/sdo_fs", {sdo, sdo_fs}, 0);
        chk(dac_strobe == 1'b0, "R8 dac_strobe", 32'(dac_strobe), 0);
        chk(dac_word == 16'h0, "R8 dac_word", 32'(dac_word), 0);
        @(negedge clk) rst_n = 1'b1;

        // R1: serial clock period
        begin
            int t0;
            @(posedge sclk); t0 = cyc;
            @(posedge sclk);
            chk(cyc - t0 == 2 * HALF, "R1 sclk period", 32'(cyc - t0), 32'(2 * HALF));
        end

        // Table of vectors: R2, R3, R4, R5, R10
        for (int v = 0; v < 6; v++) begin
            logic [2:0]  vc;
            bit          vb;
            logic [15:0] vbase;
            vc = VECS[v][19:17];
            vb = VECS[v][16];
            vbase = VECS[v][15:0];
            clear_mon();
            casc_len = vc;
            pulse_interval();
            send_words(int'(vc) + 1, vb, vbase);
            drain();
            chk(dac_n == 1, vb ? "R3 dac count" : "R4 dac count", 32'(dac_n), 1);
            chk(dac_last == mkword(vbase, int'(vc)), vc == 3'd7 ? "R10 dac word" : "R2 dac word",
                32'(dac_last), 32'(mkword(vbase, int'(vc))));
            chk(fwd_n == int'(vc), "R5 forwarded count", 32'(fwd_n), 32'(vc));
            for (int i = 0; i < int'(vc); i++)
                chk(fwd_q[i] == mkword(vbase, i), vb ? "R3 forwarded word" : "R5 forwarded word",
                    32'(fwd_q[i]), 32'(mkword(vbase, i)));
            chk(sdo == 1'b0 && sdo_fs == 1'b0, "R6 idle output", {sdo, sdo_fs}, 0);
        end

        // R7: interval pulse partway through restarts the count
        clear_mon();
        casc_len = 3'd2;
        pulse_interval();
        send_words(1, 1'b0, 16'h4444);
        pulse_interval();
        send_words(3, 1'b1, 16'hC000);
        drain();
        chk(dac_n == 1, "R7 dac count", 32'(dac_n), 1);
        chk(dac_last == mkword(16'hC000, 2), "R7 dac word", 32'(dac_last), 32'(mkword(16'hC000, 2)));
        chk(fwd_n == 3, "R7 forwarded count", 32'(fwd_n), 3);
        chk(fwd_q[0] == 16'h4444, "R7 first forwarded", 32'(fwd_q[0]), 32'h4444);

        // R9: forwarded words leave the DAC register untouched
        clear_mon();
        casc_len = 3'd3;
        pulse_interval();
        send_words(2, 1'b1, 16'h2222);
        drain();
        chk(dac_n == 0, "R9 no strobe", 32'(dac_n), 0);
        chk(dac_word == mkword(16'hC000, 2), "R9 dac held", 32'(dac_word), 32'(mkword(16'hC000, 2)));
        send_words(2, 1'b1, 16'h9999);
        drain();
        chk(dac_word == mkword(16'h9999, 1), "R9 dac after last", 32'(dac_word),
            32'(mkword(16'h9999, 1)));

        // R4: single-unit chain updates on every word
        clear_mon();
        casc_len = 3'd0;
        pulse_interval();
        send_words(3, 1'b1, 16'h0101);
        drain();
        chk(dac_n == 3, "R4 every word", 32'(dac_n), 3);
        chk(fwd_n == 0, "R4 nothing forwarded", 32'(fwd_n), 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule